// File: doc/BRIEF.md
# Receive Address and Frame-Type Filter

This block decides, for each received frame, whether the frame is accepted and whether it may be acknowledged. Upstream logic presents the frame's 48-bit BSSID, a multicast flag, a 6-bit multicast hash index and a 3-bit frame-type class, qualified by a one-cycle `frame_valid` strobe. One clock later the block answers with `accept` and `ack_ok` pulses.

Software sets up the filter through a simple write port, with a combinational read port for readback. It programs the station address, a BSSID mask, a 64-bit multicast hash filter, an 8-bit frame-type accept mask and a 3-bit PHY-error filter. The multicast filter can be written as two 32-bit words or one bit at a time by index. The BSSID comparison applies the programmable mask to both sides. Several virtual BSSes that differ only in masked-out bits therefore pass with a single compare, and frames from foreign networks that happen to agree on the unmasked bits are also accepted. A separate control field holds a receive-disable bit that gates all acceptance.

Register map (4-bit address): 0 station low word, 1 station high word (read as {control, address[47:32]}), 2 mask low, 3 mask high, 4 multicast bits 31..0, 5 multicast bits 63..32, 6 multicast set-by-index, 7 multicast clear-by-index, 8 frame-type filter, 9 PHY-error filter, 10 control field (data[15:0]), 11 start reception, 12 stop reception. Reads of 6, 7, 11 and 12 return zero.

Top module: `rx_addr_filter`

## Requirements
- R1: A unicast frame's BSSID matches when (frame_bssid & mask) equals (station & mask). The mask resets to all ones, which gives an exact match, and a cleared mask bit lets that bit differ.
- R2: Each 48-bit address or mask is written as a low 32-bit word and a high word that uses data[15:0]. A station high-word write leaves the 16-bit control field unchanged. Address 1 reads back as {control, station[47:32]}.
- R3: Multicast frames are accepted when filter bit [hash] is set. Bits 0..31 come from word address 4 and bits 32..63 from word address 5.
- R4: A write to address 6 sets filter bit data[5:0], and a write to address 7 clears it. When data is 64 or more, neither write changes the filter.
- R5: Only data[7:0] of a write to address 8 is stored as the type mask. A frame is accepted only if type-mask bit [frame_class] is 1.
- R6: A write to address 8 also loads the PHY-error filter. Data bit 9 (radar request) sets PHY bit 2. Data bit 8 (PHY-error request) sets PHY bits 0 (OFDM) and 1 (CCK). Address 9 writes the PHY filter directly from data[2:0].
- R7: `zld_en` is 1 exactly when the PHY-error filter is non-zero.
- R8: Address 8 reads back the type mask in bits 7:0. Bit 8 is 1 when PHY bit 0 or bit 1 is set, and bit 9 is 1 when PHY bit 2 is set.
- R9: Control bit 0 is receive-disable. While it is set, nothing is accepted. A write to address 11 clears it, a write to address 12 sets it, and it is set after reset.
- R10: `accept` and `ack_ok` are single-cycle pulses in the cycle after `frame_valid`. `ack_ok` is raised only for an accepted unicast frame.
- R11: After reset the outputs are 0, station and filters are 0, and the mask reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| frame_valid | input | 1 | Frame fields valid this cycle |
| frame_bssid | input | 48 | Frame BSSID |
| frame_mcast | input | 1 | Frame is multicast |
| frame_hash | input | 6 | Multicast hash index |
| frame_class | input | 3 | Frame-type class |
| accept | output | 1 | Frame accepted (registered pulse) |
| ack_ok | output | 1 | Frame may be acknowledged (registered pulse) |
| zld_en | output | 1 | Zero-length DMA reporting enable |

## Verification
A frame decision is due at the first rising edge after the `frame_valid` cycle. The bench drives the frame on a falling edge and samples `accept` and `ack_ok` on the next falling edge, which is when the registered result is visible, and it drops the strobe at that same point. A register write takes effect at the edge that captures it. The bench therefore reads back through the combinational read port, and checks `zld_en`, only on the falling edge after the write has cleared.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and register addresses of the receive filter.
// Assumes a 32-bit write bus and 48-bit addresses split 32 + 16.
package rxf_pkg;
    localparam int ADDR_W   = 48;
    localparam int WORD_W   = 32;
    localparam int HI_W     = ADDR_W - WORD_W;
    localparam int CTRL_W   = WORD_W - HI_W;
    localparam int MC_BITS  = 64;
    localparam int MC_IW    = $clog2(MC_BITS);
    localparam int TYPE_W   = 8;
    localparam int CLS_W    = $clog2(TYPE_W);
    localparam int PHY_W    = 3;
    localparam int RA_W     = 4;

    typedef enum logic [RA_W-1:0] {
        RA_STA_LO  = 4'd0,
        RA_STA_HI  = 4'd1,
        RA_MSK_LO  = 4'd2,
        RA_MSK_HI  = 4'd3,
        RA_MC_LO   = 4'd4,
        RA_MC_HI   = 4'd5,
        RA_MC_SET  = 4'd6,
        RA_MC_CLR  = 4'd7,
        RA_TYPE    = 4'd8,
        RA_PHY     = 4'd9,
        RA_CTRL    = 4'd10,
        RA_RX_ON   = 4'd11,
        RA_RX_OFF  = 4'd12
    } reg_addr_e;

    // PHY-error filter bit positions
    localparam int PHY_OFDM  = 0;
    localparam int PHY_CCK   = 1;
    localparam int PHY_RADAR = 2;
    // request / flag positions in the type register word
    localparam int REQ_PHYERR = 8;
    localparam int REQ_RADAR  = 9;
endpackage

// File: rtl/rxf_regs.sv
`timescale 1ns/1ps
// Module: rxf_regs
// Holds the software-visible filter state: station address, BSSID mask,
// multicast hash filter, type mask, PHY-error filter and control field.
// Assumes single-cycle writes; reads are combinational.
module rxf_regs
    import rxf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RA_W-1:0]     wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [RA_W-1:0]     rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   sta_addr,
    output logic [ADDR_W-1:0]   bss_mask,
    output logic [MC_BITS-1:0]  mc_filt,
    output logic [TYPE_W-1:0]   type_mask,
    output logic [PHY_W-1:0]    phy_filt,
    output logic [CTRL_W-1:0]   ctrl
);
    logic              idx_ok;
    logic [MC_IW-1:0]  idx;

    assign idx_ok = (wr_data < WORD_W'(MC_BITS));
    assign idx    = wr_data[MC_IW-1:0];

    // Address and mask words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_addr <= '0;
            bss_mask <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                RA_STA_LO: sta_addr[WORD_W-1:0]      <= wr_data;
                RA_STA_HI: sta_addr[ADDR_W-1:WORD_W] <= wr_data[HI_W-1:0];
                RA_MSK_LO: bss_mask[WORD_W-1:0]      <= wr_data;
                RA_MSK_HI: bss_mask[ADDR_W-1:WORD_W] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Multicast hash filter: bulk words and per-index set/clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_filt <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_MC_LO:  mc_filt[WORD_W-1:0]       <= wr_data;
                RA_MC_HI:  mc_filt[MC_BITS-1:WORD_W] <= wr_data;
                RA_MC_SET: if (idx_ok) mc_filt[idx]  <= 1'b1;
                RA_MC_CLR: if (idx_ok) mc_filt[idx]  <= 1'b0;
                default: ;
            endcase
        end
    end

    // Type mask and PHY-error filter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_mask <= '0;
            phy_filt  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_TYPE: begin
                    type_mask           <= wr_data[TYPE_W-1:0];
                    phy_filt[PHY_RADAR] <= wr_data[REQ_RADAR];
                    phy_filt[PHY_OFDM]  <= wr_data[REQ_PHYERR];
                    phy_filt[PHY_CCK]   <= wr_data[REQ_PHYERR];
                end
                RA_PHY: phy_filt <= wr_data[PHY_W-1:0];
                default: ;
            endcase
        end
    end

    // Control field; bit 0 is receive-disable, set out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_W'(1);
        end else if (wr_en) begin
            case (wr_addr)
                RA_CTRL:   ctrl    <= wr_data[CTRL_W-1:0];
                RA_RX_ON:  ctrl[0] <= 1'b0;
                RA_RX_OFF: ctrl[0] <= 1'b1;
                default: ;
            endcase
        end
    end

    // Readback multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_STA_LO: rd_data = sta_addr[WORD_W-1:0];
            RA_STA_HI: rd_data = {ctrl, sta_addr[ADDR_W-1:WORD_W]};
            RA_MSK_LO: rd_data = bss_mask[WORD_W-1:0];
            RA_MSK_HI: rd_data = {{CTRL_W{1'b0}}, bss_mask[ADDR_W-1:WORD_W]};
            RA_MC_LO:  rd_data = mc_filt[WORD_W-1:0];
            RA_MC_HI:  rd_data = mc_filt[MC_BITS-1:WORD_W];
            RA_TYPE: begin
                rd_data[TYPE_W-1:0] = type_mask;
                rd_data[REQ_PHYERR] = phy_filt[PHY_OFDM] | phy_filt[PHY_CCK];
                rd_data[REQ_RADAR]  = phy_filt[PHY_RADAR];
            end
            RA_PHY:    rd_data = {{(WORD_W-PHY_W){1'b0}}, phy_filt};
            RA_CTRL:   rd_data = {{(WORD_W-CTRL_W){1'b0}}, ctrl};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rxf_bssid_match.sv
`timescale 1ns/1ps
// Module: rxf_bssid_match
// Masked BSSID comparison, one octet slice per generate iteration.
// Assumes ADDR_W is a multiple of 8. Purely combinational.
module rxf_bssid_match #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] bssid,
    input  logic [ADDR_W-1:0] station,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    localparam int NOCT = ADDR_W / 8;
    logic [NOCT-1:0] oct_hit;

    for (genvar g = 0; g < NOCT; g++) begin : g_oct
        // Octet agrees on every bit the mask keeps
        assign oct_hit[g] = ((bssid[8*g +: 8] ^ station[8*g +: 8]) & mask[8*g +: 8]) == 8'h00;
    end

    assign hit = &oct_hit;
endmodule

// File: rtl/rxf_decide.sv
`timescale 1ns/1ps
// Module: rxf_decide
// Combines address hit, multicast hash bit, type mask and receive gate
// into registered accept / ack pulses one cycle after frame_valid.
module rxf_decide
    import rxf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic               frame_mcast,
    input  logic [MC_IW-1:0]   frame_hash,
    input  logic [CLS_W-1:0]   frame_class,
    input  logic               bss_hit,
    input  logic [MC_BITS-1:0] mc_filt,
    input  logic [TYPE_W-1:0]  type_mask,
    input  logic               rx_dis,
    output logic               accept,
    output logic               ack_ok
);
    logic addr_ok, acc_d;

    assign addr_ok = frame_mcast ? mc_filt[frame_hash] : bss_hit;
    assign acc_d   = frame_valid && !rx_dis && type_mask[frame_class] && addr_ok;

    // Register the decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
            ack_ok <= 1'b0;
        end else begin
            accept <= acc_d;
            ack_ok <= acc_d && !frame_mcast;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
// Module: rx_addr_filter (top)
// Receive address and frame-type filter: register file, masked BSSID
// comparator and registered decision stage. zld_en follows the PHY filter.
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RA_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [RA_W-1:0]    rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    input  logic               frame_valid,
    input  logic [ADDR_W-1:0]  frame_bssid,
    input  logic               frame_mcast,
    input  logic [MC_IW-1:0]   frame_hash,
    input  logic [CLS_W-1:0]   frame_class,
    output logic               accept,
    output logic               ack_ok,
    output logic               zld_en
);
    logic [ADDR_W-1:0]  sta_q, msk_q;
    logic [MC_BITS-1:0] mc_q;
    logic [TYPE_W-1:0]  type_q;
    logic [PHY_W-1:0]   phy_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               bss_hit;
    logic               rx_dis;

    assign rx_dis = ctrl_q[0];
    assign zld_en = |phy_q;

    rxf_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sta_addr(sta_q), .bss_mask(msk_q), .mc_filt(mc_q),
        .type_mask(type_q), .phy_filt(phy_q), .ctrl(ctrl_q)
    );

    rxf_bssid_match #(.ADDR_W(ADDR_W)) u_match (
        .bssid(frame_bssid), .station(sta_q), .mask(msk_q), .hit(bss_hit)
    );

    rxf_decide u_decide (
        .clk(clk), .rst_n(rst_n),
        .frame_valid(frame_valid), .frame_mcast(frame_mcast),
        .frame_hash(frame_hash), .frame_class(frame_class),
        .bss_hit(bss_hit), .mc_filt(mc_q), .type_mask(type_q),
        .rx_dis(rx_dis), .accept(accept), .ack_ok(ack_ok)
    );
endmodule

// File: rtl/rxf_checker.sv
`timescale 1ns/1ps
// Module: rxf_checker
// Temporal properties of rx_addr_filter, bound to the top below.
module rxf_checker
    import rxf_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [RA_W-1:0]    wr_addr,
    input logic [WORD_W-1:0]  wr_data,
    input logic               frame_valid,
    input logic               accept,
    input logic               ack_ok,
    input logic               zld_en,
    input logic               rx_dis,
    input logic [CTRL_W-1:0]  ctrl_q,
    input logic [MC_BITS-1:0] mc_q
);
    assert_ack_implies_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |-> accept);

    assert_accept_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(frame_valid));

    assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !$past(rx_dis));

    assert_ctrl_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_STA_HI) |=> $stable(ctrl_q));

    assert_bad_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == RA_MC_SET || wr_addr == RA_MC_CLR) && wr_data >= WORD_W'(MC_BITS))
        |=> $stable(mc_q));

    assert_zld_on_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_TYPE && (wr_data[REQ_PHYERR] || wr_data[REQ_RADAR])) |=> zld_en);
endmodule

bind rx_addr_filter rxf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_valid(frame_valid), .accept(accept), .ack_ok(ack_ok), .zld_en(zld_en),
    .rx_dis(rx_dis), .ctrl_q(ctrl_q), .mc_q(mc_q)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
    import rxf_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [RA_W-1:0]   wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [RA_W-1:0]   rd_addr = '0;
    logic [WORD_W-1:0] rd_data;
    logic              frame_valid = 1'b0;
    logic [ADDR_W-1:0] frame_bssid = '0;
    logic              frame_mcast = 1'b0;
    logic [MC_IW-1:0]  frame_hash = '0;
    logic [CLS_W-1:0]  frame_class = '0;
    logic              accept, ack_ok, zld_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_valid(frame_valid),
        .frame_bssid(frame_bssid), .frame_mcast(frame_mcast), .frame_hash(frame_hash),
        .frame_class(frame_class), .accept(accept), .ack_ok(ack_ok), .zld_en(zld_en)
    );

    // {mcast, hash, class, bssid, exp_accept, exp_ack}
    localparam int NV = 10;
    localparam logic [59:0] VEC [NV] = '{
        {1'b0, 6'd0,  3'd0, 48'h1234_5678_9ABC, 1'b1, 1'b1},  // R1 exact
        {1'b0, 6'd0,  3'd1, 48'h1234_5678_9ABF, 1'b1, 1'b1},  // R1 masked bits differ
        {1'b0, 6'd0,  3'd0, 48'h1234_5678_9AB8, 1'b0, 1'b0},  // R1 kept bit differs
        {1'b0, 6'd0,  3'd2, 48'h1234_5678_9ABC, 1'b0, 1'b0},  // R5 class off
        {1'b1, 6'd2,  3'd3, 48'h0,              1'b1, 1'b0},  // R3 mc bit 2
        {1'b1, 6'd1,  3'd0, 48'h0,              1'b0, 1'b0},  // R3 mc bit 1 clear
        {1'b1, 6'd63, 3'd0, 48'h0,              1'b1, 1'b0},  // R3 mc bit 63
        {1'b1, 6'd32, 3'd0, 48'h0,              1'b0, 1'b0},  // R3 mc bit 32 clear
        {1'b0, 6'd0,  3'd0, 48'h1235_5678_9ABC, 1'b0, 1'b0},  // R1 high word differs
        {1'b0, 6'd0,  3'd7, 48'h1234_5678_9ABC, 1'b0, 1'b0}   // R5 class 7 off
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [RA_W-1:0] a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [RA_W-1:0] a, output logic [WORD_W-1:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic frame(input logic mc, input logic [MC_IW-1:0] h, input logic [CLS_W-1:0] c,
                         input logic [ADDR_W-1:0] b, output logic acc, output logic ack);
        @(negedge clk);
        frame_valid = 1'b1; frame_mcast = mc; frame_hash = h; frame_class = c; frame_bssid = b;
        @(negedge clk);
        acc = accept; ack = ack_ok;
        frame_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic a, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 accept", {31'b0, accept}, 32'h0);
        chk("R11 zld_en", {31'b0, zld_en}, 32'h0);
        rd(RA_MSK_LO, r); chk("R11 mask lo", r, 32'hFFFF_FFFF);
        rd(RA_TYPE, r);   chk("R11 type", r, 32'h0);
        rd(RA_STA_HI, r); chk("R9 disabled at reset", r, 32'h0001_0000);

        wr(RA_STA_LO, 32'h5678_9ABC);
        wr(RA_STA_HI, 32'h0000_1234);
        wr(RA_MSK_LO, 32'hFFFF_FFFC);
        wr(RA_MSK_HI, 32'h0000_FFFF);
        wr(RA_MC_LO,  32'h0000_0005);
        wr(RA_MC_HI,  32'h8000_0000);
        wr(RA_TYPE,   32'h0000_000B);
        frame(1'b0, 6'd0, 3'd0, 48'h1234_5678_9ABC, a, k);
        chk("R9 gated before start", {31'b0, a}, 32'h0);
        wr(RA_RX_ON, 32'h0);

        for (int i = 0; i < NV; i++) begin
            frame(VEC[i][59], VEC[i][58:53], VEC[i][52:50], VEC[i][49:2], a, k);
            chk($sformatf("R1/R3/R5 vec%0d accept", i), {31'b0, a}, {31'b0, VEC[i][1]});
            chk($sformatf("R10 vec%0d ack", i), {31'b0, k}, {31'b0, VEC[i][0]});
        end
        // R10 pulse length
        @(negedge clk);
        chk("R10 single-cycle pulse", {31'b0, accept}, 32'h0);

        wr(RA_RX_OFF, 32'h0);
        frame(1'b0, 6'd0, 3'd0, 48'h1234_5678_9ABC, a, k);
        chk("R9 stop gates", {31'b0, a}, 32'h0);

        // R2 control preserved by high-word write
        wr(RA_CTRL, 32'h0000_A5A0);
        wr(RA_STA_HI, 32'hFFFF_1234);
        rd(RA_STA_HI, r); chk("R2 ctrl preserved", r, 32'hA5A0_1234);
        frame(1'b0, 6'd0, 3'd0, 48'h1234_5678_9ABC, a, k);
        chk("R9 restarted by ctrl", {31'b0, a}, 32'h1);

        // R1 exact mask
        wr(RA_MSK_LO, 32'hFFFF_FFFF);
        frame(1'b0, 6'd0, 3'd0, 48'h1234_5678_9ABF, a, k);
        chk("R1 exact mask rejects", {31'b0, a}, 32'h0);

        // R4 per-index set/clear
        wr(RA_MC_SET, 32'd40);
        rd(RA_MC_HI, r); chk("R4 set 40", r, 32'h8000_0100);
        wr(RA_MC_CLR, 32'd0);
        rd(RA_MC_LO, r); chk("R4 clear 0", r, 32'h0000_0004);
        wr(RA_MC_SET, 32'd64);
        wr(RA_MC_CLR, 32'd66);
        rd(RA_MC_LO, r); chk("R4 index>=64 lo", r, 32'h0000_0004);
        rd(RA_MC_HI, r); chk("R4 index>=64 hi", r, 32'h8000_0100);
        frame(1'b1, 6'd40, 3'd0, 48'h0, a, k);
        chk("R3 set bit accepts", {31'b0, a}, 32'h1);

        // R5, R6, R7, R8
        wr(RA_TYPE, 32'h0000_F00B);
        rd(RA_TYPE, r); chk("R5 low 8 stored", r, 32'h0000_000B);
        chk("R7 zld off", {31'b0, zld_en}, 32'h0);
        wr(RA_TYPE, 32'h0000_013C);
        rd(RA_PHY, r);  chk("R6 phyerr request", r, 32'h3);
        rd(RA_TYPE, r); chk("R8 phy flag", r, 32'h0000_013C);
        chk("R7 zld on", {31'b0, zld_en}, 32'h1);
        wr(RA_TYPE, 32'h0000_020B);
        rd(RA_PHY, r);  chk("R6 radar request", r, 32'h4);
        rd(RA_TYPE, r); chk("R8 radar flag", r, 32'h0000_020B);
        wr(RA_PHY, 32'h0000_0002);
        rd(RA_TYPE, r); chk("R8 cck only flag", r, 32'h0000_010B);
        chk("R7 zld cck", {31'b0, zld_en}, 32'h1);
        wr(RA_PHY, 32'h0);
        chk("R7 zld cleared", {31'b0, zld_en}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule